// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital side of a successive-approximation converter. It holds one 8-bit control word that software writes and reads back. It divides the system clock into a converter clock, and it paces conversions in units of that clock. When a conversion completes, it latches the digitised value from the `conv_din` port into two result registers and raises a completion flag. The flag drives an interrupt request, which is also gated by a local enable and a global enable.

Software uses the block as follows. It sets the enable bit and writes the start bit to begin a conversion. It then waits for the flag or the interrupt and reads the result. Free-running mode chains conversions back to back after a single start. The first start after the converter is switched on runs a longer warm-up conversion first. That warm-up produces no result.

The analog converter, the input multiplexer and the reference are outside this block. The block gives one `sample_pulse` per conversion, in the cycle in which it takes the value on `conv_din`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all eight control bits read 0, both result registers read 0 and `irq` is 0. The bit positions of `ctrl_rdata` and `reg_wdata` are:
  - bit 7: enable
  - bit 6: start/busy
  - bit 5: free-running select
  - bit 4: completion flag
  - bit 3: interrupt enable
  - bits 2:0: prescaler code
- R2: A write that clears the enable bit stops any running conversion on that same clock edge. The start bit reads 0 afterwards, no flag is raised and the result registers keep their old contents.
- R3: Writing 1 to the start bit while enable is 1 (or is being written 1) and nothing is running begins a conversion. Writing 0 to the start bit has no effect. The start bit reads 1 while a conversion runs. A normal conversion ends 13 converter clocks after the write, and the start bit reads 0 after it ends.
- R4: The first start after the enable bit goes from 0 to 1 runs a 25-clock warm-up conversion before the requested 13-clock conversion. This includes a start written in the same write as the enable. The warm-up sets no flag and changes no result. The start bit stays 1 through both conversions, 38 converter clocks in all.
- R5: With the free-running bit set, each completion starts the next conversion at once, so the results refresh every 13 converter clocks. After the bit is cleared, the conversion in progress finishes and no further conversion starts.
- R6: On the clock edge that ends a conversion, three things happen:
  - `res_lo` takes result bits 7:0;
  - `res_hi` takes result bits 9:8 in its bits 1:0, with its upper bits 0;
  - the flag is set.
- R7: The flag is cleared by a write with bit 4 set, or by `irq_ack`. A write with bit 4 at 0 leaves the flag unchanged. If a completion and a clear happen on the same edge, the flag ends at 1.
- R8: `irq` is 1 exactly when the flag, the interrupt-enable bit and `gie` are all 1.
- R9: The converter clock period, in system clocks, depends on the prescaler code:

  | Code | Period |
  |------|--------|
  | 000 | 2 |
  | 001 | 2 |
  | 010 | 4 |
  | 011 | 8 |
  | 100 | 16 |
  | 101 | 32 |
  | 110 | 64 |
  | 111 | 128 |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 8 | Control word write data |
| irq_ack | input | 1 | Interrupt acknowledge; clears the flag |
| gie | input | 1 | Global interrupt enable |
| conv_din | input | 10 | Digitised value from the analog converter |
| ctrl_rdata | output | 8 | Control word read-back; bit 6 shows busy |
| res_lo | output | 8 | Result bits 7:0 |
| res_hi | output | 8 | Result bits 9:8, zero-extended |
| sample_pulse | output | 1 | One-cycle strobe in the cycle in which `conv_din` is taken |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
Let N be the converter clock period in system clocks. Counted from the edge that takes the write, the results are due as follows:
- a normal conversion completes on the edge 13·N later;
- the warm-up pair completes on the edge 38·N later;
- in free-running mode, each later result lands another 13·N after the one before.

Control writes, aborts and flag clears show on `ctrl_rdata` one edge after the strobe. `irq` follows its inputs within the same cycle.

Each scenario checks the output on the falling edge just before the expected edge, where the block must still be busy and the old values must still hold. It then checks again on the falling edge just after, where the new values must be present. An off-by-one in the cycle count therefore fails one of the two checks. The same-edge collision between a completion and a flag clear is driven so that the write lands on the completion edge itself.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXT  = 2'd1,
    ST_NORM = 2'd2
  } conv_st_e;

  // Converter clock period in system clocks for a 3-bit prescaler code.
  function automatic logic [7:0] prescale_div(input logic [2:0] code);
    if (code == 3'd0) return 8'd2;
    return 8'(1 << code);
  endfunction

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] ps_code,
  output logic       tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim;

  assign lim  = CNT_W'(prescale_div(ps_code) - 8'd1);
  assign tick = run && (cnt_q >= lim);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: the smallest period is two system clocks, so ticks never touch
  p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
  import adc_seq_pkg::*;
#(
  parameter int NORM_CYC  = 13,
  parameter int EXT_CYC   = 25,
  parameter int SAMPLE_AT = 1,
  localparam int CYC_W    = $clog2(EXT_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic go,
  input  logic go_ext,
  input  logic kill,
  input  logic fr,
  output logic busy,
  output logic done,
  output logic sample
);

  localparam logic [CYC_W-1:0] EXT_LAST  = CYC_W'(EXT_CYC - 1);
  localparam logic [CYC_W-1:0] NORM_LAST = CYC_W'(NORM_CYC - 1);
  localparam logic [CYC_W-1:0] SAMP_IDX  = CYC_W'(SAMPLE_AT);

  conv_st_e         state_q, state_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;

  always_comb begin
    state_d = state_q;
    cyc_d   = cyc_q;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d = go_ext ? ST_EXT : ST_NORM;
          cyc_d   = '0;
        end
      end
      ST_EXT: begin
        if (tick) begin
          if (cyc_q == EXT_LAST) begin
            state_d = ST_NORM;
            cyc_d   = '0;
          end else begin
            cyc_d = cyc_q + CYC_W'(1);
          end
        end
      end
      ST_NORM: begin
        if (tick) begin
          if (cyc_q == NORM_LAST) begin
            done    = 1'b1;
            cyc_d   = '0;
            state_d = fr ? ST_NORM : ST_IDLE;
          end else begin
            cyc_d = cyc_q + CYC_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (kill) begin
      state_d = ST_IDLE;
      cyc_d   = '0;
      done    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
    end else begin
      state_q <= state_d;
      cyc_q   <= cyc_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign sample = (state_q == ST_NORM) && tick && (cyc_q == SAMP_IDX) && !kill;

  // R5: without free-running, a completion leaves the sequencer idle
  p_fr_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fr) |=> !busy);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int NORM_CYC  = 13,
  parameter int EXT_CYC   = 25,
  parameter int SAMPLE_AT = 1,
  parameter int DIV_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  input  logic             irq_ack,
  input  logic             gie,
  input  logic [RES_W-1:0] conv_din,
  output logic [7:0]       ctrl_rdata,
  output logic [7:0]       res_lo,
  output logic [7:0]       res_hi,
  output logic             sample_pulse,
  output logic             irq
);

  localparam int HI_W = RES_W - 8;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // Control state
  logic             en_q, en_d, fr_q, fr_d, flag_q, flag_d, ie_q, ie_d;
  logic [2:0]       ps_q, ps_d;
  logic             first_q, first_d;
  logic [RES_W-1:0] hold_q, data_q;
  logic             busy, done, tick, go, kill, en_new;

  assign en_new = reg_wr ? reg_wdata[7] : en_q;
  assign go     = reg_wr && reg_wdata[7] && reg_wdata[6] && !busy;
  assign kill   = reg_wr && !reg_wdata[7];

  always_comb begin
    en_d    = en_q;
    fr_d    = fr_q;
    ie_d    = ie_q;
    ps_d    = ps_q;
    if (reg_wr) begin
      en_d = reg_wdata[7];
      fr_d = reg_wdata[5];
      ie_d = reg_wdata[3];
      ps_d = reg_wdata[2:0];
    end
    flag_d = flag_q;
    if ((reg_wr && reg_wdata[4]) || irq_ack) flag_d = 1'b0;
    if (done)                                flag_d = 1'b1;
    first_d = first_q;
    if (!en_new) first_d = 1'b1;
    else if (go) first_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      en_q    <= 1'b0;
      fr_q    <= 1'b0;
      ie_q    <= 1'b0;
      ps_q    <= 3'd0;
      flag_q  <= 1'b0;
      first_q <= 1'b1;
      hold_q  <= '0;
      data_q  <= '0;
    end else begin
      en_q    <= en_d;
      fr_q    <= fr_d;
      ie_q    <= ie_d;
      ps_q    <= ps_d;
      flag_q  <= flag_d;
      first_q <= first_d;
      if (sample_pulse) hold_q <= conv_din;
      if (done)         data_q <= hold_q;
    end
  end

  adc_prescaler #(.CNT_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .run     (busy),
    .ps_code (ps_q),
    .tick    (tick)
  );

  adc_conv_fsm #(
    .NORM_CYC  (NORM_CYC),
    .EXT_CYC   (EXT_CYC),
    .SAMPLE_AT (SAMPLE_AT)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .tick   (tick),
    .go     (go),
    .go_ext (first_q),
    .kill   (kill),
    .fr     (fr_q),
    .busy   (busy),
    .done   (done),
    .sample (sample_pulse)
  );

  assign ctrl_rdata = {en_q, busy, fr_q, flag_q, ie_q, ps_q};
  assign res_lo     = data_q[7:0];
  assign res_hi     = {{(8 - HI_W){1'b0}}, data_q[RES_W-1:8]};
  assign irq        = flag_q && ie_q && gie;

  // R2: a disabled converter is never busy
  p_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    !en_q |-> !busy);
  // R6: a completion always leaves the flag set
  p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |=> flag_q);
  // R6: result registers change only on completion
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    !done |=> $stable(data_q));
  // R7: acknowledge clears the flag unless a completion coincides
  p_ack_clr_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (irq_ack && !done) |=> !flag_q);

endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic       irq_ack;
  logic       gie;
  logic [9:0] conv_din;
  logic [7:0] ctrl_rdata, res_lo, res_hi;
  logic       sample_pulse, irq;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .irq_ack      (irq_ack),
    .gie          (gie),
    .conv_din     (conv_din),
    .ctrl_rdata   (ctrl_rdata),
    .res_lo       (res_lo),
    .res_hi       (res_hi),
    .sample_pulse (sample_pulse),
    .irq          (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Called at a falling edge; returns at the falling edge after the write lands.
  task automatic wr(input logic [7:0] d);
    reg_wr    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
    reg_wdata = 8'h00;
  endtask

  task automatic t_reset;
    chk("R1 ctrl", ctrl_rdata, 8'h00);
    chk("R1 lo", res_lo, 8'h00);
    chk("R1 hi", res_hi, 8'h00);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_first_ext;  // N = 2, 38 clocks of 2
    conv_din = 10'h2A5;
    wr(8'hC0);
    step(52);
    chk("R4 busy after warm-up", ctrl_rdata[6], 1'b1);
    chk("R4 no flag from warm-up", ctrl_rdata[4], 1'b0);
    chk("R4 no data from warm-up", res_lo, 8'h00);
    step(23);
    chk("R4 busy one edge early", ctrl_rdata[6], 1'b1);
    step(1);
    chk("R4 done ctrl", ctrl_rdata, 8'h90);
    chk("R6 lo", res_lo, 8'hA5);
    chk("R6 hi", res_hi, 8'h02);
  endtask

  task automatic t_single_ps3;  // N = 8
    conv_din = 10'h13C;
    wr(8'hD3);
    chk("R7 write-1 clears flag", ctrl_rdata[4], 1'b0);
    chk("R3 busy reads 1", ctrl_rdata[6], 1'b1);
    step(103);
    chk("R9 code 3 not early", ctrl_rdata[6], 1'b1);
    step(1);
    chk("R3 done ctrl", ctrl_rdata, 8'h93);
    chk("R6 lo", res_lo, 8'h3C);
    chk("R6 hi", res_hi, 8'h01);
  endtask

  task automatic t_write_zero;
    wr(8'h83);
    step(120);
    chk("R3 start 0 no effect", ctrl_rdata, 8'h93);
    chk("R3 data untouched", res_lo, 8'h3C);
    wr(8'h93);  // read-modify-write carries the flag back as 1
    chk("R7 rmw clears flag", ctrl_rdata, 8'h83);
  endtask

  task automatic t_irq;  // N = 4
    gie = 1'b0;
    conv_din = 10'h0F0;
    wr(8'hCA);
    step(52);
    chk("R8 flag set", ctrl_rdata[4], 1'b1);
    chk("R8 gie low", irq, 1'b0);
    gie = 1'b1; #1;
    chk("R8 all set", irq, 1'b1);
    step(1);
    wr(8'h82);
    chk("R8 ie low", irq, 1'b0);
    wr(8'h8A);
    chk("R8 ie back", irq, 1'b1);
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    chk("R7 ack clears", ctrl_rdata[4], 1'b0);
    chk("R8 irq drops", irq, 1'b0);
    gie = 1'b0;
  endtask

  task automatic t_free_run;  // N = 2
    conv_din = 10'h055;
    wr(8'hE0);
    step(25);
    chk("R5 first not early", ctrl_rdata[4], 1'b0);
    step(1);
    chk("R5 first ctrl", ctrl_rdata, 8'hF0);
    chk("R5 first lo", res_lo, 8'h55);
    conv_din = 10'h3AA;
    step(26);
    chk("R5 second lo", res_lo, 8'hAA);
    chk("R5 second hi", res_hi, 8'h03);
    chk("R5 still busy", ctrl_rdata[6], 1'b1);
    wr(8'h90);
    step(24);
    chk("R5 current runs on", ctrl_rdata[6], 1'b1);
    step(1);
    chk("R5 stop ctrl", ctrl_rdata, 8'h90);
    step(30);
    chk("R5 stays stopped", ctrl_rdata, 8'h90);
  endtask

  task automatic t_abort;
    conv_din = 10'h1FF;
    wr(8'hD0);
    step(10);
    wr(8'h00);
    chk("R2 abort same edge", ctrl_rdata, 8'h00);
    step(40);
    chk("R2 no flag", ctrl_rdata, 8'h00);
    chk("R2 data kept", res_lo, 8'hAA);
    wr(8'hC0);
    step(52);
    chk("R4 re-enable warm-up", ctrl_rdata[6], 1'b1);
    chk("R4 re-enable no flag", ctrl_rdata[4], 1'b0);
    step(24);
    chk("R4 re-enable ctrl", ctrl_rdata, 8'h90);
    chk("R4 re-enable lo", res_lo, 8'hFF);
    chk("R4 re-enable hi", res_hi, 8'h01);
  endtask

  task automatic t_prescale;
    wr(8'hD1);
    step(25);
    chk("R9 code 1 busy", ctrl_rdata[6], 1'b1);
    step(1);
    chk("R9 code 1 done", ctrl_rdata, 8'h91);
    wr(8'hD7);
    step(1663);
    chk("R9 code 7 busy", ctrl_rdata[6], 1'b1);
    step(1);
    chk("R9 code 7 done", ctrl_rdata, 8'h97);
  endtask

  task automatic t_collide;  // N = 2
    wr(8'hD0);
    step(25);
    wr(8'h90);  // lands on the completion edge
    chk("R7 set beats write clear", ctrl_rdata, 8'h90);
    wr(8'hD0);
    step(25);
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    chk("R7 set beats ack", ctrl_rdata[4], 1'b1);
  endtask

  initial begin
    #2_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    irq_ack = 1'b0; gie = 1'b0; conv_din = 10'h000;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_first_ext();
    t_single_ps3();
    t_write_zero();
    t_irq();
    t_free_run();
    t_abort();
    t_prescale();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule